// File: doc/BRIEF.md
# Four-Way Cache Victim Selector

This block decides which way of a four-way set-associative cache set receives a new line when a lookup misses. It holds the per-set state itself: a valid bit, a priority bit and a 2-bit age for each of the four ways, for a parameterised number of sets. The caller drives a set index. From the stored state of that set, the block presents the set's valid bits and the chosen victim way as combinational outputs, in one-hot and in encoded form.

Invalid ways are always taken first, and among them the lowest-numbered one wins. When the set is full, a line that was filled with its priority bit set is protected: the oldest low-priority way is evicted. Only when every way in the set carries the priority mark does the oldest way overall go.

The surrounding cache controller uses three strobes to tell the block what happened. A hit update refreshes the recency of one way. A fill commit installs a line together with its priority bit. A per-way invalidate drops a line. Each strobe takes effect on the next clock edge for the addressed set. An internal action decode with three named actions (ACT_IDLE, ACT_HIT, ACT_FILL) selects which way, if any, becomes the newest.

Top module: `cache_victim_sel`

## Requirements
- R1: `victim_onehot` always has exactly one bit set, and that bit is bit `victim_enc`. The encoded value 0..3 is the way number.
- R2: When the addressed set has at least one way with its valid bit at 0, the victim is a way whose valid bit is 0.
- R3: Among several invalid ways, the lowest-numbered one is chosen. Examples: ways 0 and 1 invalid gives 0; ways 2 and 3 invalid gives 2; only way 3 invalid gives 3.
- R4: When all four ways are valid and at least one has a stored priority bit of 0, the victim is the least recently used way among those with priority 0.
- R5: When all four ways are valid and all have a stored priority bit of 1, the victim is the least recently used way of the set.
- R6: A fill commit at a clock edge sets the valid bit of `fill_way` in the addressed set and stores `fill_prio` for it. It also makes that way the most recently used. Only the ways that were more recent than it age by one step.
- R7: A hit update at a clock edge makes `hit_way` the most recently used, using the same aging rule. It does not change any valid or priority bit.
- R8: When fill commit and hit update are strobed in the same cycle, only the fill is applied and the hit is ignored.
- R9: An invalidate clears the valid and priority bits of `inval_way` in the addressed set and leaves the recency order unchanged. If a fill commit targets the same way in the same cycle, the fill wins and the line ends valid.
- R10: Strobes change only the set selected by `set_idx`, and all other sets keep their state.
- R11: Synchronous reset clears every valid and priority bit in every set, so every set reports `way_valid` = 0000 and victim way 0. It also sets the recency order of each set to way 0 oldest through way 3 newest.
- R12: `way_valid` shows the valid bits of the addressed set combinationally, with bit n for way n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | SET_W | Addressed set for outputs and strobes |
| hit_upd | input | 1 | Hit update strobe |
| hit_way | input | 2 | Way that hit |
| fill_commit | input | 1 | Fill commit strobe |
| fill_way | input | 2 | Way being filled |
| fill_prio | input | 1 | Priority bit of the incoming line (1 = protected) |
| inval | input | 1 | Invalidate strobe |
| inval_way | input | 2 | Way to invalidate |
| way_valid | output | 4 | Valid bits of the addressed set |
| victim_onehot | output | 4 | Chosen victim way, one-hot |
| victim_enc | output | 2 | Chosen victim way, encoded |

## Verification
The hardest situation to reach from the ports is a full set in which the oldest way is protected while an only slightly younger way is not. The R4 rule must then skip the overall least recently used line, and a plain LRU would give a different answer. The stimulus gets there with a scripted mix of fills at different priority bits, hits that reorder ages, and an invalidate followed by a refill. The recency state is computed by hand at every step, so each expected victim is known exactly. Same-cycle collisions of fill with hit and of fill with invalidate on the same way are driven as directed cases, where the two possible orderings lead to different victims.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    localparam int unsigned WAYS  = 4;
    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned AGE_W = $clog2(WAYS);

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [AGE_W-1:0] age_t;

    // Age 0 is most recently used; age WAYS-1 is least recently used.
    typedef struct packed {
        logic [WAYS-1:0] vld;
        logic [WAYS-1:0] pri;
        age_t [WAYS-1:0] age;
    } set_st_t;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_HIT  = 2'd1,
        ACT_FILL = 2'd2
    } touch_act_t;

    function automatic set_st_t reset_state();
        set_st_t s;
        s.vld = '0;
        s.pri = '0;
        for (int w = 0; w < int'(WAYS); w++) begin
            s.age[w] = age_t'(int'(WAYS) - 1 - w);
        end
        return s;
    endfunction

endpackage

// File: rtl/vsel_age_touch.sv
module vsel_age_touch
    import vsel_pkg::*;
(
    input  age_t [WAYS-1:0] age_i,
    input  logic            touch_i,
    input  way_t            way_i,
    output age_t [WAYS-1:0] age_o
);

    age_t ref_age;

    always_comb begin
        ref_age = age_i[way_i];
        for (int w = 0; w < int'(WAYS); w++) begin
            if (!touch_i) begin
                age_o[w] = age_i[w];
            end else if (way_i == way_t'(w)) begin
                age_o[w] = '0;
            end else if (age_i[w] < ref_age) begin
                age_o[w] = age_i[w] + age_t'(1);
            end else begin
                age_o[w] = age_i[w];
            end
        end
    end

endmodule

// File: rtl/vsel_victim_pick.sv
module vsel_victim_pick
    import vsel_pkg::*;
(
    input  logic [WAYS-1:0] vld_i,
    input  logic [WAYS-1:0] pri_i,
    input  age_t [WAYS-1:0] age_i,
    output logic [WAYS-1:0] onehot_o,
    output way_t            enc_o
);

    logic [WAYS-1:0] free_ways;
    logic [WAYS-1:0] cand_ways;
    logic            any_free;
    logic            any_lowp;
    way_t            free_sel;
    way_t            lru_sel;
    age_t            best_age;
    logic            found;

    always_comb begin
        free_ways = ~vld_i;
        any_free  = |free_ways;
        any_lowp  = |(~pri_i);

        // Downward scan so the lowest free way is the last one written.
        free_sel = '0;
        for (int w = int'(WAYS) - 1; w >= 0; w--) begin
            if (free_ways[w]) begin
                free_sel = way_t'(w);
            end
        end

        // With priority protection, only low-priority lines compete, unless none exist.
        cand_ways = any_lowp ? ~pri_i : '1;
        lru_sel   = '0;
        best_age  = '0;
        found     = 1'b0;
        for (int w = 0; w < int'(WAYS); w++) begin
            if (cand_ways[w] && (!found || age_i[w] > best_age)) begin
                lru_sel  = way_t'(w);
                best_age = age_i[w];
                found    = 1'b1;
            end
        end

        enc_o    = any_free ? free_sel : lru_sel;
        onehot_o = WAYS'(1) << enc_o;
    end

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
    import vsel_pkg::*;
#(
    parameter  int unsigned NUM_SETS = 16,
    localparam int unsigned SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_upd,
    input  logic [1:0]       hit_way,
    input  logic             fill_commit,
    input  logic [1:0]       fill_way,
    input  logic             fill_prio,
    input  logic             inval,
    input  logic [1:0]       inval_way,
    output logic [3:0]       way_valid,
    output logic [3:0]       victim_onehot,
    output logic [1:0]       victim_enc
);

    set_st_t         st_q [NUM_SETS];
    set_st_t         cur_st;
    set_st_t         nxt_st;
    touch_act_t      act;
    way_t            touch_way;
    logic            touch_en;
    logic            wr_any;
    age_t [WAYS-1:0] aged;

    assign cur_st = st_q[set_idx];

    // Action decode: a fill outranks a hit in the same cycle.
    always_comb begin
        if (fill_commit) begin
            act = ACT_FILL;
        end else if (hit_upd) begin
            act = ACT_HIT;
        end else begin
            act = ACT_IDLE;
        end
    end

    always_comb begin
        unique case (act)
            ACT_FILL: begin
                touch_way = fill_way;
                touch_en  = 1'b1;
            end
            ACT_HIT: begin
                touch_way = hit_way;
                touch_en  = 1'b1;
            end
            default: begin
                touch_way = '0;
                touch_en  = 1'b0;
            end
        endcase
    end

    vsel_age_touch u_age (
        .age_i   (cur_st.age),
        .touch_i (touch_en),
        .way_i   (touch_way),
        .age_o   (aged)
    );

    always_comb begin
        nxt_st     = cur_st;
        nxt_st.age = aged;
        if (inval) begin
            nxt_st.vld[inval_way] = 1'b0;
            nxt_st.pri[inval_way] = 1'b0;
        end
        unique case (act)
            ACT_FILL: begin
                nxt_st.vld[fill_way] = 1'b1;
                nxt_st.pri[fill_way] = fill_prio;
            end
            ACT_HIT, ACT_IDLE: begin
            end
            default: begin
            end
        endcase
    end

    assign wr_any = fill_commit | hit_upd | inval;

    for (genvar s = 0; s < int'(NUM_SETS); s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[s] <= reset_state();
            end else if (wr_any && (set_idx == SET_W'(s))) begin
                st_q[s] <= nxt_st;
            end
        end
    end

    vsel_victim_pick u_pick (
        .vld_i    (cur_st.vld),
        .pri_i    (cur_st.pri),
        .age_i    (cur_st.age),
        .onehot_o (victim_onehot),
        .enc_o    (victim_enc)
    );

    assign way_valid = cur_st.vld;

    // R1: one-hot and encoded forms agree
    a_r1_onehot_match: assert property (@(posedge clk) disable iff (rst)
        $onehot(victim_onehot) && victim_onehot[victim_enc]);

    // R2: a free way is never passed over for a valid one
    a_r2_free_first: assert property (@(posedge clk) disable iff (rst)
        (way_valid != 4'hF) |-> !way_valid[victim_enc]);

    // R6: a committed fill leaves its way valid and newest
    a_r6_fill_newest: assert property (@(posedge clk) disable iff (rst)
        fill_commit |=> (st_q[$past(set_idx)].vld[$past(fill_way)]
                         && st_q[$past(set_idx)].age[$past(fill_way)] == '0));

    // R9: an invalidate not overridden by a fill clears the line
    a_r9_inval_clears: assert property (@(posedge clk) disable iff (rst)
        (inval && !(fill_commit && fill_way == inval_way))
            |=> !st_q[$past(set_idx)].vld[$past(inval_way)]);

    // R11: right after reset the addressed set is empty
    a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (way_valid == 4'h0 && victim_enc == 2'd0));

endmodule

// File: tb/cache_victim_sel_tb_top.sv
module cache_victim_sel_tb_top;

    localparam int SETS = 16;
    localparam int SW   = $clog2(SETS);
    localparam int NVEC = 19;

    localparam logic [1:0] OP_NONE = 2'd0;
    localparam logic [1:0] OP_HIT  = 2'd1;
    localparam logic [1:0] OP_FILL = 2'd2;
    localparam logic [1:0] OP_INV  = 2'd3;

    // {op[14:13], set[12:9], way[8:7], prio[6], exp_enc[5:4], exp_valid[3:0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {OP_FILL, 4'd0, 2'd0, 1'b0, 2'd1, 4'b0001},
        {OP_FILL, 4'd0, 2'd1, 1'b0, 2'd2, 4'b0011},
        {OP_FILL, 4'd0, 2'd3, 1'b1, 2'd2, 4'b1011},
        {OP_FILL, 4'd0, 2'd2, 1'b0, 2'd0, 4'b1111},
        {OP_HIT,  4'd0, 2'd0, 1'b0, 2'd1, 4'b1111},
        {OP_HIT,  4'd0, 2'd1, 1'b0, 2'd2, 4'b1111},
        {OP_HIT,  4'd0, 2'd2, 1'b0, 2'd0, 4'b1111},
        {OP_INV,  4'd0, 2'd1, 1'b0, 2'd1, 4'b1101},
        {OP_FILL, 4'd0, 2'd1, 1'b1, 2'd0, 4'b1111},
        {OP_FILL, 4'd0, 2'd0, 1'b1, 2'd2, 4'b1111},
        {OP_FILL, 4'd0, 2'd2, 1'b1, 2'd3, 4'b1111},
        {OP_HIT,  4'd0, 2'd3, 1'b0, 2'd1, 4'b1111},
        {OP_INV,  4'd0, 2'd0, 1'b0, 2'd0, 4'b1110},
        {OP_INV,  4'd0, 2'd2, 1'b0, 2'd0, 4'b1010},
        {OP_FILL, 4'd0, 2'd0, 1'b0, 2'd2, 4'b1011},
        {OP_NONE, 4'd5, 2'd0, 1'b0, 2'd0, 4'b0000},
        {OP_FILL, 4'd5, 2'd0, 1'b0, 2'd1, 4'b0001},
        {OP_NONE, 4'd0, 2'd0, 1'b0, 2'd2, 4'b1011},
        {OP_FILL, 4'd0, 2'd2, 1'b0, 2'd0, 4'b1111}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] set_idx = '0;
    logic          hit_upd = 1'b0;
    logic [1:0]    hit_way = '0;
    logic          fill_commit = 1'b0;
    logic [1:0]    fill_way = '0;
    logic          fill_prio = 1'b0;
    logic          inval = 1'b0;
    logic [1:0]    inval_way = '0;
    logic [3:0]    way_valid;
    logic [3:0]    victim_onehot;
    logic [1:0]    victim_enc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    cache_victim_sel #(.NUM_SETS(SETS)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .set_idx       (set_idx),
        .hit_upd       (hit_upd),
        .hit_way       (hit_way),
        .fill_commit   (fill_commit),
        .fill_way      (fill_way),
        .fill_prio     (fill_prio),
        .inval         (inval),
        .inval_way     (inval_way),
        .way_valid     (way_valid),
        .victim_onehot (victim_onehot),
        .victim_enc    (victim_enc)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive strobes for one clock edge, then release them and settle.
    task automatic drive(input int s, input bit h, input int hw, input bit f, input int fw,
                         input bit fp, input bit iv, input int iw);
        @(negedge clk);
        set_idx     = SW'(s);
        hit_upd     = h;
        hit_way     = 2'(hw);
        fill_commit = f;
        fill_way    = 2'(fw);
        fill_prio   = fp;
        inval       = iv;
        inval_way   = 2'(iw);
        @(negedge clk);
        hit_upd     = 1'b0;
        fill_commit = 1'b0;
        inval       = 1'b0;
        #1;
    endtask

    task automatic look(input int s, input int exp_valid, input int exp_enc, input string req);
        set_idx = SW'(s);
        #1;
        chk(way_valid == 4'(exp_valid), {req, " valid"}, int'(way_valid), exp_valid);
        chk(victim_enc == 2'(exp_enc), {req, " victim"}, int'(victim_enc), exp_enc);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog (R1 all) actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R11: reset state seen on several sets
        look(0, 0, 0, "R11 reset set0");
        look(7, 0, 0, "R11 reset set7");
        look(15, 0, 0, "R11 reset set15");

        // Vector table: R2 R3 R4 R5 R6 R7 R9 R10 R12 expectations, R1 each step
        for (int i = 0; i < NVEC; i++) begin
            logic [14:0] v;
            v = VEC[i];
            drive(int'(v[12:9]),
                  v[14:13] == OP_HIT,  int'(v[8:7]),
                  v[14:13] == OP_FILL, int'(v[8:7]), v[6],
                  v[14:13] == OP_INV,  int'(v[8:7]));
            chk(way_valid == v[3:0], $sformatf("vec%0d R12 R6 R9 R10 valid", i),
                int'(way_valid), int'(v[3:0]));
            chk(victim_enc == v[5:4], $sformatf("vec%0d R2 R3 R4 R5 R7 victim", i),
                int'(victim_enc), int'(v[5:4]));
            chk(victim_onehot == (4'b0001 << v[5:4]), $sformatf("vec%0d R1 onehot", i),
                int'(victim_onehot), int'(4'b0001 << v[5:4]));
        end

        // R8: fill set7 ways 0..3 at low priority, then fill w1 and hit w0 together
        for (int w = 0; w < 4; w++) begin
            drive(7, 1'b0, 0, 1'b1, w, 1'b0, 1'b0, 0);
        end
        look(7, 15, 0, "R4 full set7");
        drive(7, 1'b1, 0, 1'b1, 1, 1'b0, 1'b0, 0);
        look(7, 15, 0, "R8 fill over hit");

        // R9: invalidate and fill on the same way in one cycle
        drive(7, 1'b0, 0, 1'b1, 1, 1'b0, 1'b1, 1);
        look(7, 15, 0, "R9 fill over inval");

        // R7: hit on way 0 moves it to newest; way 2 becomes oldest
        drive(7, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0, 0);
        look(7, 15, 2, "R7 hit reorders");

        // R11: reset in mid-run empties all sets
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        look(0, 0, 0, "R11 rerst set0");
        look(7, 0, 0, "R11 rerst set7");
        look(5, 0, 0, "R11 rerst set5");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule